// File: doc/BRIEF.md
# External bus request arbiter

This block decides who drives a shared external bus: the chip's own CPU bus interface, or a single external master that asks for the bus through an active-low request pin. When handover is enabled and a request is seen, the arbiter waits for a safe point. It then floats every bus-facing pin group through output-enable controls, stops the CPU from starting new bus cycles, and drives an active-low acknowledge pin.

The CPU side supplies four status inputs. The first marks the boundary between bus cycles. The second marks a word transfer that is split into two byte accesses and has only its first half done. The third shows internal-only work such as a multiply or divide, and the fourth shows sleep. Handover waits for a cycle boundary when the CPU is using the bus, and it is never made in the middle of a split word. It is immediate when the CPU is only working internally or is asleep. The bus comes back to the CPU after the request pin has read high on two consecutive samples.

The request pin passes through a synchronizer. The synchronizer's delay counts toward the minimum interval from request to acknowledge. A pad counter adds the missing cycles when that minimum is set longer than the synchronizer delay.

Top module: `ext_bus_arbiter`

## Requirements
- R1: While `rel_en` is 0, a low `breq_n` has no effect: `bus_ack_n` stays 1 and the CPU keeps the bus.
- R2: `breq_n` is sampled on each rising clock edge, and a 0 sample is a request. With defaults (`SYNC_STAGES`=2, `MIN_STATES`=3) and a transfer point present, `bus_ack_n` falls right after the third rising edge that samples the pin low. It is still 1 after the second such edge.
- R3: With `MIN_STATES`=5 and a transfer point present, `bus_ack_n` falls right after the fifth rising edge that samples the pin low, and not before.
- R4: While the CPU is busy on the bus (`cyc_boundary`=0, `cpu_internal`=0, `cpu_sleep`=0), a pending request is held. It is granted right after the first edge at which `cyc_boundary`=1 is sampled.
- R5: While `split_lock`=1, the bus is not released, even when `cyc_boundary`, `cpu_internal` or `cpu_sleep` is 1.
- R6: When `cpu_internal`=1 or `cpu_sleep`=1 (and `split_lock`=0), the bus is released without waiting for a cycle boundary.
- R7: While released, `bus_ack_n`, `cpu_grant`, `addr_oe`, `data_oe`, all four bits of `strobe_oe` (bit 3 address strobe, bit 2 read strobe, bit 1 high write strobe, bit 0 low write strobe) and all eight bits of `cs_oe` are 0. At all other times they are all 1.
- R8: A release ends only after `breq_n` is sampled 1 on two consecutive edges. `bus_ack_n` returns to 1 right after the fourth edge counted from the first high sample, and a single high sample between low samples does not end the release.
- R9: Clearing `rel_en` while a request is still waiting for a transfer point cancels that request. Clearing `rel_en` during a release does not end the release.
- R10: During and after reset, the CPU owns the bus and `bus_ack_n`, `cpu_grant` and all output enables are 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| breq_n | input | 1 | External bus request, active low |
| rel_en | input | 1 | Handover enable control bit |
| cyc_boundary | input | 1 | CPU is at a bus-cycle boundary |
| split_lock | input | 1 | First byte of a split word is done and the second is pending |
| cpu_internal | input | 1 | CPU is doing internal-only work |
| cpu_sleep | input | 1 | CPU is in sleep mode |
| bus_ack_n | output | 1 | Bus acknowledge, active low |
| cpu_grant | output | 1 | CPU may start bus cycles |
| addr_oe | output | 1 | Address bus output enable |
| data_oe | output | 1 | Data bus output enable |
| strobe_oe | output | 4 | Strobe output enables {AS, RD, HWR, LWR} |
| cs_oe | output | CS_COUNT | Chip-select output enables |

## Verification
The bench walks through all sixteen combinations of the four CPU status inputs. Each request is checked edge by edge, so a design that releases one cycle early breaks the three-state minimum, and one that ignores the split lock hands over between byte halves. A one-sample high glitch during release is driven to catch a design that ends the release on a single high sample. Cancelling by clearing the enable while the request waits catches a sticky flag that outlives its enable. A second instance with a longer minimum checks that the pad counter delays the acknowledge and does not drop the request.

// File: rtl/ext_bus_arbiter.sv
module ext_bus_arbiter #(
  parameter int SYNC_STAGES = 2,
  parameter int MIN_STATES  = 3,
  parameter int CS_COUNT    = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                breq_n,
  input  logic                rel_en,
  input  logic                cyc_boundary,
  input  logic                split_lock,
  input  logic                cpu_internal,
  input  logic                cpu_sleep,
  output logic                bus_ack_n,
  output logic                cpu_grant,
  output logic                addr_oe,
  output logic                data_oe,
  output logic [3:0]          strobe_oe,
  output logic [CS_COUNT-1:0] cs_oe
);

  // Synchronizer delay plus the decision edge already gives SYNC_STAGES+1 states.
  localparam int PAD = (MIN_STATES > SYNC_STAGES + 1) ? MIN_STATES - SYNC_STAGES - 1 : 0;
  localparam int CW  = $clog2(PAD + 2);

  typedef enum logic [1:0] {CPU_OWNS, WAIT_BOUNDARY, RELEASED} arb_state_e;

  arb_state_e             state, state_n;
  logic [SYNC_STAGES-1:0] sync_q;
  logic                   req_s, hi_prev, want, xfer_ok, pad_ok, ack_q;
  logic [CW-1:0]          pad_cnt;

  assign req_s   = sync_q[SYNC_STAGES-1];
  assign want    = rel_en & ~req_s;
  assign xfer_ok = ~split_lock & (cyc_boundary | cpu_internal | cpu_sleep);
  assign pad_ok  = pad_cnt >= CW'(PAD);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sync_q  <= '1;
      hi_prev <= 1'b1;
    end else begin
      sync_q  <= {sync_q[SYNC_STAGES-2:0], breq_n};
      hi_prev <= req_s;
    end

  // WAIT_BOUNDARY is the sticky request: it holds until a transfer point or until rel_en drops.
  always_comb begin
    state_n = state;
    case (state)
      CPU_OWNS:      if (want) state_n = (xfer_ok && pad_ok) ? RELEASED : WAIT_BOUNDARY;
      WAIT_BOUNDARY: if (!rel_en) state_n = CPU_OWNS;
                     else if (xfer_ok && pad_ok) state_n = RELEASED;
      RELEASED:      if (req_s && hi_prev) state_n = CPU_OWNS;
      default:       state_n = CPU_OWNS;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      state   <= CPU_OWNS;
      pad_cnt <= '0;
      ack_q   <= 1'b1;
    end else begin
      state <= state_n;
      ack_q <= (state_n != RELEASED);
      if (state_n != WAIT_BOUNDARY) pad_cnt <= '0;
      else if (!pad_ok)             pad_cnt <= pad_cnt + 1'b1;
    end

  assign bus_ack_n = ack_q;
  assign cpu_grant = ack_q;
  assign addr_oe   = ack_q;
  assign data_oe   = ack_q;
  assign strobe_oe = {4{ack_q}};
  assign cs_oe     = {CS_COUNT{ack_q}};

  assert_disabled_holds_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (!rel_en && bus_ack_n) |=> bus_ack_n);

  assert_split_blocks_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (split_lock && bus_ack_n) |=> bus_ack_n);

  assert_only_at_point_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(bus_ack_n) |-> $past(~split_lock & (cyc_boundary | cpu_internal | cpu_sleep)));

  assert_two_high_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_ack_n) |-> ($past(req_s) && $past(hi_prev)));

  assert_enables_float_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (state == RELEASED) |-> (!bus_ack_n && cs_oe == '0 && strobe_oe == '0));

endmodule

// File: tb/ext_bus_arbiter_tb_top.sv
module ext_bus_arbiter_tb_top;
  logic clk = 1'b0, rst_n = 1'b0;
  logic breq_n = 1'b1, rel_en = 1'b1, cyc_boundary = 1'b0, split_lock = 1'b0;
  logic cpu_internal = 1'b0, cpu_sleep = 1'b0;
  logic ack_a, grant_a, aoe_a, doe_a, ack_b, grant_b, aoe_b, doe_b;
  logic [3:0] soe_a, soe_b;
  logic [7:0] cs_a, cs_b;
  int checks = 0, errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  ext_bus_arbiter dut_i (.clk(clk), .rst_n(rst_n), .breq_n(breq_n), .rel_en(rel_en),
    .cyc_boundary(cyc_boundary), .split_lock(split_lock), .cpu_internal(cpu_internal),
    .cpu_sleep(cpu_sleep), .bus_ack_n(ack_a), .cpu_grant(grant_a), .addr_oe(aoe_a),
    .data_oe(doe_a), .strobe_oe(soe_a), .cs_oe(cs_a));

  ext_bus_arbiter #(.MIN_STATES(5)) dut_pad (.clk(clk), .rst_n(rst_n), .breq_n(breq_n),
    .rel_en(rel_en), .cyc_boundary(cyc_boundary), .split_lock(split_lock),
    .cpu_internal(cpu_internal), .cpu_sleep(cpu_sleep), .bus_ack_n(ack_b),
    .cpu_grant(grant_b), .addr_oe(aoe_b), .data_oe(doe_b), .strobe_oe(soe_b), .cs_oe(cs_b));

  wire [15:0] bund_a = {ack_a, grant_a, aoe_a, doe_a, soe_a, cs_a};
  wire [15:0] bund_b = {ack_b, grant_b, aoe_b, doe_b, soe_b, cs_b};

  task automatic step(input int n = 1);
    repeat (n) @(negedge clk);
  endtask

  // exp_owned = 1: CPU owns the bus, so every output is 1.
  task automatic chk(input string req, input logic [15:0] act, input bit exp_owned);
    logic [15:0] exp = exp_owned ? 16'hFFFF : 16'h0000;
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic set_status(input logic b, input logic s, input logic i, input logic z);
    cyc_boundary = b; split_lock = s; cpu_internal = i; cpu_sleep = z;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    step(3);
    chk("R10 in reset", bund_a, 1);
    rst_n = 1'b1;
    step(2);
    chk("R10 after reset", bund_a, 1);
    chk("R10 after reset pad", bund_b, 1);

    // Sweep all status combinations.
    for (int c = 0; c < 16; c++) begin
      bit ok;
      set_status(c[3], c[2], c[1], c[0]);
      ok = !c[2] && (c[3] || c[1] || c[0]);
      breq_n = 1'b0;
      step(2);
      chk("R2 not before third edge", bund_a, 1);
      step(1);
      if (ok) chk((c[3] ? "R4 boundary grant" : "R6 idle immediate"), bund_a, 0);
      else if (c[2]) chk("R5 split holds", bund_a, 1);
      else chk("R4 busy holds", bund_a, 1);
      if (!ok) begin
        step(2);
        chk("R4 R5 still waiting", bund_a, 1);
        set_status(1'b1, 1'b0, c[1], c[0]);
        step(1);
        chk("R4 granted at boundary", bund_a, 0);
      end
      breq_n = 1'b1;
      step(3);
      chk("R8 held through two high samples", bund_a, 0);
      chk("R7 all enables low", bund_a, 0);
      step(1);
      chk("R8 returned", bund_a, 1);
      step(8);
    end

    // Single high sample during release.
    set_status(1'b0, 1'b0, 1'b1, 1'b0);
    breq_n = 1'b0;
    step(3);
    chk("R6 internal release", bund_a, 0);
    breq_n = 1'b1;
    step(1);
    breq_n = 1'b0;
    step(5);
    chk("R8 glitch ignored", bund_a, 0);
    breq_n = 1'b1;
    step(4);
    chk("R8 end after glitch", bund_a, 1);
    step(8);

    // Enable off: request ignored.
    rel_en = 1'b0;
    breq_n = 1'b0;
    for (int i = 0; i < 8; i++) begin
      step(1);
      chk("R1 request ignored", bund_a, 1);
    end
    breq_n = 1'b1;
    step(4);

    // Cancel a waiting request.
    rel_en = 1'b1;
    set_status(1'b0, 1'b0, 1'b0, 1'b0);
    breq_n = 1'b0;
    step(4);
    chk("R9 waiting", bund_a, 1);
    rel_en = 1'b0;
    step(1);
    breq_n = 1'b1;
    step(3);
    set_status(1'b1, 1'b0, 1'b0, 1'b0);
    rel_en = 1'b1;
    step(3);
    chk("R9 cancelled request not granted", bund_a, 1);
    step(4);

    // Enable off during release keeps the release.
    breq_n = 1'b0;
    step(3);
    chk("R9 released", bund_a, 0);
    rel_en = 1'b0;
    step(3);
    chk("R9 release kept with enable off", bund_a, 0);
    rel_en = 1'b1;
    breq_n = 1'b1;
    step(4);
    chk("R9 release ended", bund_a, 1);
    step(8);

    // Padding instance.
    set_status(1'b0, 1'b0, 1'b0, 1'b1);
    breq_n = 1'b0;
    for (int i = 1; i <= 6; i++) begin
      step(1);
      chk("R3 padded acknowledge", bund_b, i < 5);
      chk("R2 default acknowledge", bund_a, i < 3);
    end
    breq_n = 1'b1;
    step(8);
    chk("R8 padded instance returned", bund_b, 1);

    finish_run();
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end
endmodule